// File: doc/BRIEF.md
# Buffered Clock-Synchronous Serial Master Transmitter

This block drives a clock-synchronous serial link as the master. It produces the serial clock, an active-low chip select and the data line. Software writes bytes into a one-byte holding register. A byte in the holding register moves into the shift register as soon as the shifter is free. Because of this, a stream of bytes can leave the block as one continuous burst, with no gap and with chip select held low the whole time.

Two status outputs tell the writer what to do next. `tx_empty` shows that the holding register may take a new byte. `tx_end` shows that the line has gone quiet. Two configuration inputs set how a transfer ends. The first chooses whether chip select is released one system clock after the final bit or one full bit time after it. The second chooses whether `tx_end` rises as soon as the final bit is done or only when chip select goes high.

A byte must reach the holding register before the second-to-last bit of the current byte starts in order to chain. A byte that arrives later is kept. It is sent as a separate transfer once the current one has closed, after chip select has been high for at least one bit time.

Top module: `ser_mtx`

## Requirements
- R1: While reset is asserted and directly after it, `cs_n`=1, `sclk`=1, `tx_empty`=1 and `tx_end`=1.
- R2: A write while idle starts a transfer. The data is sent most significant bit first. In the cycle after the write's clock edge, `tx_empty` and `tx_end` are both 0 and `cs_n` is still 1. One cycle later, `cs_n`=0, `sclk`=0 and bit 7 is on `mosi`.
- R3: Let H equal `div`, with a `div` of 0 treated as 1. Each bit lasts 2*H system clocks: `sclk` is 0 for the first H and 1 for the last H. `mosi` changes only where `sclk` falls.
- R4: `tx_empty` is 0 from the clock edge of a write until the clock edge at which that byte enters the shift register. It is 1 at all other times.
- R5: A byte written at a clock edge where the current byte's bit index (0 = MSB) is still 5 or lower chains. Its MSB starts in the bit period right after the current LSB, and `cs_n` stays 0.
- R6: A byte written at an edge where the current byte's bit index is 6 or 7 does not chain. It starts its own transfer one cycle after the current transfer's chip-select gap ends.
- R7: After the final bit, when no byte chains, `cs_n` stays 0 for a tail. The tail is 2*H cycles when `cs_auto` is 0 and 1 cycle when `cs_auto` is 1. After the tail, `cs_n` is 1 for a gap of 2*H cycles during which no transfer starts.
- R8: With `end_at_cs`=0, `tx_end` rises on the first tail cycle, while `cs_n` is still 0. With `end_at_cs`=1, it rises on the first gap cycle, together with `cs_n` going to 1.
- R9: Every write clears `tx_end`. `tx_end` stays 0 while bits are shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| div | input | DIV_W | Half-bit length in system clocks (0 acts as 1) |
| cs_auto | input | 1 | 1: release chip select one cycle after the final bit; 0: one bit time after it |
| end_at_cs | input | 1 | 1: raise `tx_end` when chip select is released; 0: raise it when the final bit is done |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| tx_empty | output | 1 | Holding register can take a byte |
| tx_end | output | 1 | Transmission finished |

## Verification
Every result is due at a fixed cycle offset from the write's clock edge. Both flags move one edge after the write. The first bit appears one edge after that. Bit b of byte n spans the cycles 1+(8n+b)*2H through (8n+b+1)*2H after the write edge. The tail begins at cycle 16H*bytes+1, and the gap begins right after the tail. The bench samples every output on the falling clock edge of every cycle and compares it with a value computed from these offsets. It drives chaining writes at the last cycle that still chains (edge 12H+1) and at the first cycle that does not (edge 12H+2).

// File: rtl/ser_mtx_pkg.sv
package ser_mtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2,
    ST_GAP   = 2'd3
  } ser_state_t;

endpackage

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic [CW-1:0] cnt,
  output logic          tc
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tc  = run && (cnt_q >= lim);
  assign cnt = cnt_q;

  always_comb begin
    if (!run || tc) cnt_d = '0;
    else            cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          shift,
  output logic          msb,
  output logic          last,
  output logic          zone
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);
  localparam logic [IW-1:0] ZONE_IDX = IW'(DW - 2);

  logic [DW-1:0] sh_q, sh_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          en;

  assign en = load || shift;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load) begin
      sh_d  = ld_data;
      idx_d = '0;
    end else if (shift) begin
      sh_d  = {sh_q[DW-2:0], 1'b0};
      idx_d = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign msb  = sh_q[DW-1];
  assign last = (idx_q == LAST_IDX);
  assign zone = (idx_q >= ZONE_IDX);

endmodule

// File: rtl/ser_hold.sv
module ser_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  input  logic          late_zone,
  output logic          full,
  output logic          late,
  output logic [DW-1:0] data
);

  logic          full_q, full_d;
  logic          late_q, late_d;
  logic [DW-1:0] data_q;

  always_comb begin
    full_d = full_q;
    late_d = late_q;
    if (take)  full_d = 1'b0;
    if (wr_en) begin
      full_d = 1'b1;
      late_d = late_zone;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      late_q <= 1'b0;
    end else begin
      full_q <= full_d;
      late_q <= late_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (wr_en) data_q <= wr_data;
  end

  assign full = full_q;
  assign late = late_q;
  assign data = data_q;

  assert_full_after_write_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full_q);

endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_mtx_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int CW    = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             cs_auto,
  input  logic             end_at_cs,
  input  logic             wr_en,
  input  logic             full,
  input  logic             late,
  input  logic             last,
  input  logic             tc,
  input  logic [CW-1:0]    cnt,
  output logic             run,
  output logic [CW-1:0]    lim,
  output logic             load,
  output logic             shift,
  output logic             in_zone,
  output logic             sclk,
  output logic             cs_n,
  output logic             tx_end
);

  ser_state_t       st_q, st_d;
  logic [DIV_W-1:0] half_q, half_in;
  logic             end_q, end_d;
  logic             start, chain, enter_tail, enter_gap;
  logic [CW-1:0]    bit_lim;

  assign half_in = (div == '0) ? DIV_W'(1) : div;
  assign bit_lim = {half_q, 1'b0} - CW'(1);

  assign start      = (st_q == ST_IDLE) && full;
  assign chain      = (st_q == ST_SHIFT) && tc && last && full && !late;
  assign enter_tail = (st_q == ST_SHIFT) && tc && last && !(full && !late);
  assign enter_gap  = (st_q == ST_TAIL) && tc;

  assign load    = start || chain;
  assign shift   = (st_q == ST_SHIFT) && tc && !last;
  assign run     = (st_q != ST_IDLE);
  assign in_zone = (st_q == ST_SHIFT);

  always_comb begin
    unique case (st_q)
      ST_SHIFT: lim = bit_lim;
      ST_TAIL:  lim = cs_auto ? '0 : bit_lim;
      ST_GAP:   lim = bit_lim;
      default:  lim = '0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (full) st_d = ST_SHIFT;
      ST_SHIFT: if (enter_tail) st_d = ST_TAIL;
      ST_TAIL:  if (tc) st_d = ST_GAP;
      ST_GAP:   if (tc) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    end_d = end_q;
    if (enter_tail && !end_at_cs) end_d = 1'b1;
    if (enter_gap)                end_d = 1'b1;
    if (start)                    end_d = 1'b0;
    if (wr_en)                    end_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      end_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      end_q <= end_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     half_q <= DIV_W'(1);
    else if (start) half_q <= half_in;
  end

  assign sclk   = !((st_q == ST_SHIFT) && (cnt < {1'b0, half_q}));
  assign cs_n   = !((st_q == ST_SHIFT) || (st_q == ST_TAIL));
  assign tx_end = end_q;

  assert_end_low_while_shifting_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT) |-> !end_q);

  assert_end_with_deselect_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (end_at_cs && $rose(end_q)) |-> cs_n);

endmodule

// File: rtl/ser_mtx.sv
module ser_mtx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  div,
  input  logic              cs_auto,
  input  logic              end_at_cs,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              tx_empty,
  output logic              tx_end
);

  localparam int CW = DIV_W + 1;
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic              run, tc, load, shift, in_zone;
  logic [CW-1:0]     lim, cnt;
  logic              full, late, last, zone;
  logic [DATA_W-1:0] hold_data;

  ser_bit_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .lim(lim), .cnt(cnt), .tc(tc)
  );

  ser_hold #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(load), .late_zone(in_zone && zone),
    .full(full), .late(late), .data(hold_data)
  );

  ser_shifter #(.DW(DATA_W), .IW(IW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_data(hold_data),
    .shift(shift), .msb(mosi), .last(last), .zone(zone)
  );

  ser_ctrl #(.DIV_W(DIV_W), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .div(div), .cs_auto(cs_auto),
    .end_at_cs(end_at_cs), .wr_en(wr_en), .full(full), .late(late),
    .last(last), .tc(tc), .cnt(cnt), .run(run), .lim(lim),
    .load(load), .shift(shift), .in_zone(in_zone),
    .sclk(sclk), .cs_n(cs_n), .tx_end(tx_end)
  );

  assign tx_empty = !full;

  assert_mosi_moves_on_fall_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi));

  assert_sclk_idles_deselected_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

endmodule

// File: tb/ser_mtx_tb.sv
module ser_mtx_tb;

  localparam int DATA_W = 8;
  localparam int DIV_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DIV_W-1:0]  div = '0;
  logic              cs_auto = 1'b0;
  logic              end_at_cs = 1'b0;
  logic              sclk, cs_n, mosi, tx_empty, tx_end;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ser_mtx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .div(div),
    .cs_auto(cs_auto), .end_at_cs(end_at_cs), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .tx_empty(tx_empty), .tx_end(tx_end)
  );

  task automatic cmp(input string tag, input int t, input logic [4:0] got,
                     input logic [4:0] exp, input logic [4:0] mask);
    n_chk++;
    if ((got & mask) !== (exp & mask)) begin
      n_bad++;
      $display("FAIL %s t=%0d {cs_n,sclk,mosi,empty,end} got %b exp %b (mask %b)",
               tag, t, got, exp, mask);
    end
  endtask

  // mode 0: single byte; 1: chained second byte written at edge w; 2: late second byte
  task automatic run_case(input int h, input int mode, input int w,
                          input logic [7:0] d0, input logic [7:0] d1);
    int l, s1, p, tend;
    l    = cs_auto ? 1 : 2 * h;
    s1   = 16 * h * ((mode == 1) ? 2 : 1);
    p    = 16 * h + l + 2 * h + 1;
    tend = (mode == 2) ? (p + 16 * h + l + 2 * h + 3) : (s1 + l + 2 * h + 3);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d0;
    @(posedge clk);
    for (int t = 0; t <= tend; t++) begin
      int tt, nb, s, ph, bi;
      bit sec;
      logic e_cs, e_sclk, e_mosi, e_emp, e_end;
      logic [4:0] m;
      string tag;
      @(negedge clk);
      wr_en = 1'b0;
      sec = (mode == 2) && (t >= p);
      tt  = sec ? t - p : t;
      nb  = (mode == 1) ? 2 : 1;
      s   = 16 * h * nb;
      e_cs = 1'b1; e_sclk = 1'b1; e_mosi = 1'b0; e_emp = 1'b1; e_end = 1'b1;
      m = 5'b11011;
      tag = sec ? "R6" : "R1";
      if (tt == 0) begin
        e_end = sec ? 1'b1 : 1'b0;
        e_emp = 1'b0;
        tag = sec ? "R6" : "R2/R9";
      end else if (tt <= s) begin
        ph = (tt - 1) % (2 * h);
        bi = (tt - 1) / (2 * h);
        e_cs = 1'b0;
        e_sclk = (ph >= h);
        e_mosi = ((bi >= 8 || sec) ? d1[7 - (bi % 8)] : d0[7 - (bi % 8)]);
        e_end = 1'b0;
        m = 5'b11111;
        tag = (mode == 1 && bi >= 8) ? "R5" : "R2/R3/R4/R9";
      end else if (tt <= s + l) begin
        e_cs = 1'b0;
        e_end = !end_at_cs;
        tag = "R7/R8";
      end else if (tt <= s + l + 2 * h) begin
        tag = "R7/R8";
      end
      if (!sec && mode == 1 && t >= w && t <= 16 * h) e_emp = 1'b0;
      if (!sec && mode == 2 && t >= w) e_emp = 1'b0;
      cmp(tag, t, {cs_n, sclk, mosi, tx_empty, tx_end},
          {e_cs, e_sclk, e_mosi, e_emp, e_end}, m);
      if (mode != 0 && t + 1 == w) begin
        wr_en   = 1'b1;
        wr_data = d1;
      end
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", -1, {cs_n, sclk, 1'b0, tx_empty, tx_end}, 5'b11011, 5'b11011);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", 0, {cs_n, sclk, 1'b0, tx_empty, tx_end}, 5'b11011, 5'b11011);
    for (int dv = 0; dv < 4; dv++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        for (int md = 0; md < 4; md++) begin
          int h, k;
          logic [7:0] a, b;
          h = (dv == 0) ? 1 : dv;
          k = dv * 16 + cfg * 4 + md;
          a = 8'hA5 ^ 8'(k * 37);
          b = ~{a[3:0], a[7:4]};
          @(negedge clk);
          div       = DIV_W'(dv);
          cs_auto   = cfg[0];
          end_at_cs = cfg[1];
          case (md)
            0: run_case(h, 0, 0, a, b);
            1: run_case(h, 1, 2, a, b);           // R5 earliest chaining write
            2: run_case(h, 1, 12 * h + 1, a, b);  // R5 last edge that still chains
            default: run_case(h, 2, 12 * h + 2, a, b); // R6 first late edge
          endcase
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule